// File: doc/BRIEF.md
# Gated Frequency Meter

The block estimates the rate of an unknown pulse train by counting its rising edges over a fixed number of reference clock cycles. A window counter, armed by software, behaves as a retriggerable one-shot. While its window is open, a second counter steps down from all ones once per measured edge. When the window closes, the block raises a completion flag and presents the number of edges seen. If the edge counter ran out during the window, a sticky flag marks the result as unusable.

Software writes the window length and then raises the start control bit. It polls the completion flag, and then reads the count and the invalid flag. The measured input is asynchronous. It passes through a flop synchroniser and an edge detector clocked by the reference clock before anything counts it. A new rising edge on the start bit begins a fresh measurement, even while a window is still running.

Top module: `freq_gate_meter`

## Requirements
- R1: After reset, windowOpen, done and overflow are 0 and pulseCount is 0.
- R2: A start edge is startBit at 1 while it was 0 in the previous cycle. With a nonzero windowLen of N, windowOpen is 1 for exactly N cycles, starting the cycle after the edge. Holding startBit at 1 never starts another window.
- R3: Rising edges of sigIn are counted only while windowOpen is 1. Edges arriving while the window is closed leave pulseCount unchanged.
- R4: done rises in the same cycle that windowOpen falls at the end of a window. It then stays at 1 until the next start edge.
- R5: The edge counter is preset to all ones and decrements once per counted edge. pulseCount equals all ones minus the remaining value. If the counter reaches zero, overflow latches at 1 and the count holds at its maximum (63 with a 6-bit counter).
- R6: Every start edge clears done, overflow and pulseCount in the next cycle.
- R7: A start edge while a window is open restarts the window with the full length and discards the edges counted so far.
- R8: A start edge with windowLen equal to 0 opens no window, and sets done the next cycle with pulseCount at 0.
- R9: sigIn is synchronised with two flops and then edge detected. A pulse held high for two cycles and low for two cycles counts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startBit | input | 1 | Start control bit; its rising edge begins a measurement |
| windowLen | input | WIN_W | Window length in reference cycles |
| sigIn | input | 1 | Asynchronous measured pulse input |
| windowOpen | output | 1 | High while the measurement window is open |
| done | output | 1 | Measurement complete |
| overflow | output | 1 | Edge counter exhausted; result invalid |
| pulseCount | output | CNT_W | Edges counted in the last or current window |

## Verification
The bench builds the block with a 6-bit edge counter and a 10-bit window. With these widths, exhausting the counter takes only 63 edges, while a window of up to 1023 cycles still holds more than 63 edges. This makes the overflow boundary reachable at 62, 63 and 80 edges within a short run. The wide window is also used to count the open cycles exactly, both after a normal start and after a restart in mid-window.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic clear;   // start edge: preset edge counter, clear overflow
    logic gateEn;  // window open: edges may be counted
  } fgm_strobe_t;
endpackage

// File: rtl/fgm_ctrl.sv
module fgm_ctrl
  import fgm_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBit,
  input  logic [WIN_W-1:0] windowLen,
  output fgm_strobe_t      strobe,
  output logic             windowOpen,
  output logic             done
);
  localparam logic [WIN_W-1:0] WinOne = WIN_W'(1);

  logic             startQ;
  logic [WIN_W-1:0] winCnt;
  logic             startEdge;

  assign startEdge = startBit & ~startQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ     <= 1'b0;
      windowOpen <= 1'b0;
      done       <= 1'b0;
      winCnt     <= '0;
    end else begin
      startQ <= startBit;
      if (startEdge) begin
        winCnt     <= windowLen;
        windowOpen <= (windowLen != '0);
        done       <= (windowLen == '0);
      end else if (windowOpen) begin
        winCnt <= winCnt - WinOne;
        if (winCnt == WinOne) begin
          windowOpen <= 1'b0;
          done       <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.clear  = startEdge;
    strobe.gateEn = windowOpen;
  end

  // R2: a start edge with a nonzero length opens the window
  a_r2_open_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (startEdge && windowLen != '0) |=> windowOpen);
  // R4: window closing coincides with done
  a_r4_done_on_close: assert property (@(posedge clk) disable iff (!rstN)
    $fell(windowOpen) |-> done);
  // R6: start edge clears done for a real window
  a_r6_start_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    (startEdge && windowLen != '0) |=> !done);
  // R4: done and an open window never coexist
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && windowOpen));
endmodule

// File: rtl/fgm_datapath.sv
module fgm_datapath
  import fgm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  fgm_strobe_t      strobe,
  input  logic             sigIn,
  output logic             overflow,
  output logic [CNT_W-1:0] pulseCount
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);
  localparam int               TopBit = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sigPrev;
  logic                   sigRise;
  logic [CNT_W-1:0]       remain;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sigIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sigIn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sigPrev <= 1'b0;
    else       sigPrev <= syncQ[TopBit];
  end

  assign sigRise = syncQ[TopBit] & ~sigPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain   <= '1;
      overflow <= 1'b0;
    end else if (strobe.clear) begin
      remain   <= '1;
      overflow <= 1'b0;
    end else if (strobe.gateEn && sigRise && !overflow) begin
      remain <= remain - CntOne;
      if (remain == CntOne) overflow <= 1'b1;
    end
  end

  assign pulseCount = ~remain;

  // R3: a closed window leaves the edge counter untouched
  a_r3_hold_when_closed: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.gateEn && !strobe.clear) |=> $stable(remain));
  // R5: overflow is sticky until a start edge
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.clear) |=> overflow);
  // R5: an exhausted counter is always flagged
  a_r5_zero_flags: assert property (@(posedge clk) disable iff (!rstN)
    (remain == '0) |-> overflow);
  // R6: a start edge presets the counter
  a_r6_clear_count: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (pulseCount == '0 && !overflow));
endmodule

// File: rtl/freq_gate_meter.sv
module freq_gate_meter
  import fgm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBit,
  input  logic [WIN_W-1:0] windowLen,
  input  logic             sigIn,
  output logic             windowOpen,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] pulseCount
);
  fgm_strobe_t strobe;

  fgm_ctrl #(.WIN_W(WIN_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startBit   (startBit),
    .windowLen  (windowLen),
    .strobe     (strobe),
    .windowOpen (windowOpen),
    .done       (done)
  );

  fgm_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sigIn      (sigIn),
    .overflow   (overflow),
    .pulseCount (pulseCount)
  );
endmodule

// File: tb/test_freq_gate_meter.sv
module test_freq_gate_meter;
  localparam int CNT_W = 6;
  localparam int WIN_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startBit = 1'b0;
  logic [WIN_W-1:0] windowLen = '0;
  logic             sigIn = 1'b0;
  logic             windowOpen, done, overflow;
  logic [CNT_W-1:0] pulseCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  freq_gate_meter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_freq_gate_meter (
    .clk(clk), .rstN(rstN), .startBit(startBit), .windowLen(windowLen),
    .sigIn(sigIn), .windowOpen(windowOpen), .done(done),
    .overflow(overflow), .pulseCount(pulseCount)
  );

  task automatic check(input int actual, input int expected, input string tag);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // raise startBit from 0; returns at the negedge after the start edge
  task automatic startPulse(input int len);
    @(negedge clk);
    windowLen = WIN_W'(len);
    startBit  = 1'b0;
    @(negedge clk);
    startBit = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sigIn = 1'b1; @(negedge clk); @(negedge clk);
      sigIn = 1'b0; @(negedge clk); @(negedge clk);
    end
  endtask

  // count open cycles while driving n pulses; returns when the window closes
  task automatic runWindow(input int n, output int openCycles);
    int cnt = 0;
    fork
      begin
        while (windowOpen) begin cnt++; @(negedge clk); end
      end
      pulses(n);
    join
    openCycles = cnt;
  endtask

  task automatic testReset();
    check(int'(windowOpen), 0, "R1 windowOpen");
    check(int'(done), 0, "R1 done");
    check(int'(overflow), 0, "R1 overflow");
    check(int'(pulseCount), 0, "R1 pulseCount");
  endtask

  task automatic testBasic();
    int openC;
    startPulse(100);
    check(int'(windowOpen), 1, "R2 window opens");
    check(int'(done), 0, "R6 done cleared");
    runWindow(10, openC);
    check(openC, 100, "R2 window length");
    check(int'(done), 1, "R4 done at close");
    check(int'(pulseCount), 10, "R9 each pulse counted once");
    check(int'(overflow), 0, "R5 no overflow");
  endtask

  task automatic testIgnoredOutside();
    pulses(5);
    repeat (6) @(negedge clk);
    check(int'(pulseCount), 10, "R3 edges outside window ignored");
    check(int'(done), 1, "R4 done held");
    check(int'(windowOpen), 0, "R2 held startBit does not retrigger");
  endtask

  task automatic testOverflow(input int n, input int expCount, input int expOvf);
    int openC;
    startPulse(1000);
    runWindow(n, openC);
    check(openC, 1000, "R2 long window length");
    check(int'(pulseCount), expCount, "R5 count at boundary");
    check(int'(overflow), expOvf, "R5 overflow flag");
  endtask

  task automatic testClearOnStart();
    int openC;
    startPulse(50);
    check(int'(overflow), 0, "R6 overflow cleared");
    check(int'(done), 0, "R6 done cleared");
    check(int'(pulseCount), 0, "R6 count cleared");
    runWindow(0, openC);
    check(int'(pulseCount), 0, "R3 no edges no count");
  endtask

  task automatic testRestart();
    int openC;
    startPulse(200);
    pulses(5);
    repeat (4) @(negedge clk);
    check(int'(pulseCount), 5, "R3 counting in window");
    startPulse(200);
    check(int'(windowOpen), 1, "R7 window still open");
    check(int'(pulseCount), 0, "R7 count discarded");
    runWindow(3, openC);
    check(openC, 200, "R7 full length after restart");
    check(int'(pulseCount), 3, "R7 count after restart");
  endtask

  task automatic testZeroLen();
    startPulse(0);
    check(int'(done), 1, "R8 done at once");
    check(int'(windowOpen), 0, "R8 no window");
    check(int'(pulseCount), 0, "R8 zero count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testIgnoredOutside();
    testOverflow(62, 62, 0);
    testOverflow(63, 63, 1);
    testOverflow(80, 63, 1);
    testClearOnStart();
    testRestart();
    testZeroLen();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule